// File: doc/BRIEF.md
# CC Comparator Status Glitch Filter

This block sits between the two Configuration Channel comparators of a USB Type-C port controller and the status bits that software reads. The comparators switch without reference to the system clock, so each raw bit first passes through a two-stage synchronizer. A per-channel qualifier then rejects short pulses and publishes a new level only after the synchronized input has held it for a set number of prescaler ticks. Any change back to the published level before that count completes throws the partial count away.

A one-cycle strobe marks every software write to the CC control register, which holds the pull-up/pull-down choice and the comparator threshold. The strobe restarts the tick prescaler and both qualifiers, and it drops the valid flag. The flag returns only after one full qualification interval. Longer connection debounce is left to software, which samples the status bits periodically. With the default 48 MHz clock, a tick is 480 cycles (10 µs) and 47 ticks are required. Pulses of 460 µs or less are therefore always rejected, and a held level is published within about 470 µs. Both values fall between the 450 µs rejection bound and the 560 µs latency bound.

In the requirements below, D is `TICK_DIV` and Q is `QUAL_TICKS`. An "edge" is a rising clock edge.

Top module: `cc_status_filter`

## Requirements
- R1: While reset is asserted and right after it is released, both filtered bits are 0 and the valid flag is 0.
- R2: The two channels are independent. Bit 0 of `cc_raw` affects only bit 0 of `cc_filt`, and bit 1 affects only bit 1.
- R3: A raw pulse away from the published level never changes that channel's filtered bit if it lasts (Q-1)*D clock cycles or fewer.
- R4: When a raw input moves to a new level and holds it, the filtered bit shows that level no later than Q*D+2 edges after the first edge that samples it. This applies to both rising and falling changes.
- R5: If the synchronized input is sampled at the published level even once, the partial count is discarded. Pulses separated by such gaps never add up, however many arrive.
- R6: A `ctrl_wr` pulse clears `status_valid` at the edge that samples it. That edge leaves both filtered bits unchanged and restarts both qualifiers and the prescaler.
- R7: `status_valid` rises exactly Q*D edges after the edge that sampled the last `ctrl_wr`, or after reset release. It falls only on a `ctrl_wr`.
- R8: If a `ctrl_wr` lands on the same edge where a channel would finish qualifying, the write takes priority. The filtered bit keeps its old level, and qualification of the held level finishes at the same edge where `status_valid` rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cc_raw | input | NCH (2) | Raw comparator outputs, bit 0 = CC1, bit 1 = CC2 |
| ctrl_wr | input | 1 | One-cycle strobe for a CC control register write |
| cc_filt | output | NCH (2) | Filtered comparator levels, bit 0 = CC1, bit 1 = CC2 |
| status_valid | output | 1 | High when the filtered levels reflect a full interval since the last write or reset |

## Verification
Two functions can fall on the same edge. A control write can coincide with a channel finishing qualification, and the valid flag can rise on the same edge where a held level qualifies. The bench provokes the first case in a specific order. It issues one write, changes CC2 just after it, and issues a second write exactly Q*D edges after the first. At that edge the new level would have qualified and the valid flag would have risen. The result is judged by checking that CC2 and the valid flag both stay low at that edge, then stay low until one edge before the next interval ends, and then both go high together on the interval's final edge.

// File: rtl/ccf_pkg.sv
package ccf_pkg;
  // Defaults for a 48 MHz clock: 480-cycle tick (10 us), 47 ticks to qualify.
  localparam int unsigned CCF_TICK_DIV_DEF   = 480;
  localparam int unsigned CCF_QUAL_TICKS_DEF = 47;
  localparam int unsigned CCF_NCH_DEF        = 2;

  // Shortest mismatch run (cycles) that can ever be published.
  function automatic int unsigned ccf_min_accept(input int unsigned div, input int unsigned qt);
    return (qt - 1) * div + 1;
  endfunction
endpackage

// File: rtl/ccf_sync.sv
module ccf_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/ccf_prescaler.sv
module ccf_prescaler #(
  parameter int unsigned DIV = 480
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase;

  assign tick = (phase == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= '0;
    else if (restart) phase <= '0;
    else if (tick)    phase <= '0;
    else              phase <= phase + 1'b1;
  end
endmodule

// File: rtl/ccf_blank.sv
module ccf_blank #(
  parameter int unsigned QT = 47
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic tick,
  output logic valid
);
  localparam int unsigned CW = (QT > 1) ? $clog2(QT) : 1;
  localparam logic [CW-1:0] LAST = CW'(QT - 1);

  logic [CW-1:0] ticks_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ticks_seen <= '0;
      valid      <= 1'b0;
    end else if (restart) begin
      ticks_seen <= '0;
      valid      <= 1'b0;
    end else if (tick && !valid) begin
      if (ticks_seen == LAST) valid <= 1'b1;
      else                    ticks_seen <= ticks_seen + 1'b1;
    end
  end
endmodule

// File: rtl/ccf_chan.sv
module ccf_chan #(
  parameter int unsigned QT = 47
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic tick,
  input  logic s,
  output logic level
);
  localparam int unsigned CW = (QT > 1) ? $clog2(QT) : 1;
  localparam logic [CW-1:0] LAST = CW'(QT - 1);

  logic [CW-1:0] run;
  logic          differs;

  assign differs = (s != level);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= '0;
      level <= 1'b0;
    end else if (restart || !differs) begin
      run <= '0;
    end else if (tick) begin
      if (run == LAST) begin
        level <= s;
        run   <= '0;
      end else begin
        run <= run + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cc_status_filter.sv
module cc_status_filter
  import ccf_pkg::*;
#(
  parameter int unsigned NCH        = CCF_NCH_DEF,
  parameter int unsigned TICK_DIV   = CCF_TICK_DIV_DEF,
  parameter int unsigned QUAL_TICKS = CCF_QUAL_TICKS_DEF
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] cc_raw,
  input  logic           ctrl_wr,
  output logic [NCH-1:0] cc_filt,
  output logic           status_valid
);
  logic [NCH-1:0] cc_sync;
  logic           tick;

  ccf_sync #(.W(NCH)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(cc_raw), .q(cc_sync)
  );

  ccf_prescaler #(.DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(ctrl_wr), .tick(tick)
  );

  ccf_blank #(.QT(QUAL_TICKS)) u_blank (
    .clk(clk), .rst_n(rst_n), .restart(ctrl_wr), .tick(tick), .valid(status_valid)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    ccf_chan #(.QT(QUAL_TICKS)) u_ch (
      .clk(clk), .rst_n(rst_n), .restart(ctrl_wr), .tick(tick),
      .s(cc_sync[i]), .level(cc_filt[i])
    );
  end
endmodule

// File: rtl/cc_status_filter_chk.sv
module cc_status_filter_chk #(
  parameter int unsigned NCH        = 2,
  parameter int unsigned TICK_DIV   = 480,
  parameter int unsigned QUAL_TICKS = 47
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ctrl_wr,
  input logic [NCH-1:0] cc_sync,
  input logic [NCH-1:0] cc_filt,
  input logic           status_valid
);
  localparam int unsigned RLIM = (QUAL_TICKS - 1) * TICK_DIV;
  localparam int unsigned SLIM = QUAL_TICKS * TICK_DIV + 1;
  localparam int unsigned RW   = $clog2(RLIM + 1) + 1;
  localparam int unsigned SW   = $clog2(SLIM + 1) + 1;

  logic [SW-1:0] since_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_wr <= '0;
    else if (ctrl_wr)           since_wr <= '0;
    else if (since_wr != SW'(SLIM)) since_wr <= since_wr + 1'b1;
  end

  // R7: valid rises exactly one full interval after a write or reset
  p_valid_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_valid) |-> since_wr == SW'(QUAL_TICKS * TICK_DIV));

  // R7: valid only falls because of a write
  p_valid_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_valid) |-> $past(ctrl_wr));

  // R6: a write blanks valid and leaves the filtered bits alone
  p_wr_blanks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> !status_valid && $stable(cc_filt));

  for (genvar i = 0; i < NCH; i++) begin : g_run
    logic [RW-1:0] mis_run;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          mis_run <= '0;
      else if (ctrl_wr || cc_sync[i] == cc_filt[i]) mis_run <= '0;
      else if (mis_run != RW'(RLIM))       mis_run <= mis_run + 1'b1;
    end

    // R3, R5: a short mismatch run cannot move the published level
    p_reject_short_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_wr && cc_sync[i] != cc_filt[i] && mis_run < RW'(RLIM)) |=> $stable(cc_filt[i]));

    // R4: a published bit only ever moves to the synchronized level
    p_follow_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cc_filt[i]) |-> cc_filt[i] == $past(cc_sync[i]));
  end
endmodule

bind cc_status_filter cc_status_filter_chk #(
  .NCH(NCH), .TICK_DIV(TICK_DIV), .QUAL_TICKS(QUAL_TICKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .cc_sync(cc_sync),
  .cc_filt(cc_filt), .status_valid(status_valid)
);

// File: tb/tb_cc_status_filter.sv
module tb_cc_status_filter;
  localparam int CLK_PERIOD = 10;
  localparam int D  = 4;
  localparam int Q  = 5;
  localparam int IV = Q * D;          // full interval in edges
  localparam int SHORT = (Q - 1) * D; // longest pulse always rejected
  localparam int LAT = IV + 2;        // worst-case publish latency

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cc_raw = 2'b00;
  logic       ctrl_wr = 1'b0;
  logic [1:0] cc_filt;
  logic       status_valid;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  cc_status_filter #(.NCH(2), .TICK_DIV(D), .QUAL_TICKS(Q)) dut (
    .clk(clk), .rst_n(rst_n), .cc_raw(cc_raw), .ctrl_wr(ctrl_wr),
    .cc_filt(cc_filt), .status_valid(status_valid)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_wr();
    ctrl_wr = 1'b1;
    step(1);
    ctrl_wr = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 filt in reset", cc_filt, 0);
    check("R1 valid in reset", status_valid, 0);
    rst_n = 1'b1;
    check("R1 filt after release", cc_filt, 0);
    step(IV - 1);
    check("R7 valid one edge early after reset", status_valid, 0);
    step(1);
    check("R7 valid at interval end after reset", status_valid, 1);
  endtask

  task automatic t_qualify_cc1();
    cc_raw[0] = 1'b1;
    step(LAT);
    check("R4 CC1 rises within bound", cc_filt[0], 1);
    check("R2 CC2 untouched by CC1", cc_filt[1], 0);
    check("R7 valid stays high", status_valid, 1);
  endtask

  task automatic t_reject_cc2();
    int bad = 0;
    cc_raw[1] = 1'b1;
    for (int k = 0; k < SHORT; k++) begin
      step(1);
      if (cc_filt[1] !== 1'b0) bad++;
    end
    cc_raw[1] = 1'b0;
    for (int k = 0; k < 3 * IV; k++) begin
      step(1);
      if (cc_filt[1] !== 1'b0) bad++;
    end
    check("R3 short CC2 pulse rejected", bad, 0);
    check("R2 CC1 held during CC2 pulse", cc_filt[0], 1);
  endtask

  task automatic t_split_pulses();
    int bad = 0;
    for (int p = 0; p < 5; p++) begin
      cc_raw[1] = 1'b1;
      for (int k = 0; k < SHORT; k++) begin
        step(1);
        if (cc_filt[1] !== 1'b0) bad++;
      end
      cc_raw[1] = 1'b0;
      step(1);
      if (cc_filt[1] !== 1'b0) bad++;
    end
    for (int k = 0; k < LAT; k++) begin
      step(1);
      if (cc_filt[1] !== 1'b0) bad++;
    end
    check("R5 gapped pulses never accumulate", bad, 0);
  endtask

  task automatic t_release_cc1();
    cc_raw[0] = 1'b0;
    step(LAT);
    check("R4 CC1 falls within bound", cc_filt[0], 0);
  endtask

  task automatic t_write();
    cc_raw = 2'b00;
    step(LAT);
    cc_raw[0] = 1'b1;
    step(3);
    pulse_wr();
    check("R6 valid cleared by write", status_valid, 0);
    check("R6 filt unchanged by write", cc_filt, 0);
    step(IV - 1);
    check("R7 valid one edge early after write", status_valid, 0);
    check("R6 CC1 qualification restarted", cc_filt[0], 0);
    step(1);
    check("R7 valid at interval end after write", status_valid, 1);
    check("R6 CC1 qualifies with restarted interval", cc_filt[0], 1);
  endtask

  task automatic t_collide();
    pulse_wr();
    cc_raw[1] = 1'b1;
    step(IV - 1);
    check("R8 CC2 pending before collision", cc_filt[1], 0);
    pulse_wr();
    check("R8 write wins over CC2 completion", cc_filt[1], 0);
    check("R8 write wins over valid rise", status_valid, 0);
    step(IV - 1);
    check("R8 CC2 still held before second interval end", cc_filt[1], 0);
    check("R8 valid low before second interval end", status_valid, 0);
    step(1);
    check("R8 CC2 qualifies with valid", cc_filt[1], 1);
    check("R8 valid rises with CC2", status_valid, 1);
    check("R2 CC1 unaffected", cc_filt[0], 1);
  endtask

  initial begin
    t_reset();
    t_qualify_cc1();
    t_reject_cc2();
    t_split_pulses();
    t_release_cc1();
    t_write();
    t_collide();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule